// File: doc/BRIEF.md
# Reset Sequencing Controller

This block decides when the chip's clock generator, core, peripherals and SDRAM controller leave reset. Three causes of reset lead into it. The first is an external active-low pin. The second is a software reset bit in the system control register. The third is a running-reset request line.

Each cause resets a different set of domains.
- Pin reset: resets all four domains. After the pin is released, the block waits out the full PLL lock time before releasing the core side.
- Software reset: leaves the PLL running and resets everything else for a short fixed hold.
- Running reset: spares both the PLL and the SDRAM controller, so auto-refresh keeps running.

Releasing a pin or software reset raises a one-cycle boot request when the boot configuration is valid. Releasing a running reset never raises a boot request. It raises a program-counter load strobe with the fixed internal-memory start address instead.

All pins are plain control and status signals. There is no streaming interface, so there is no valid/ready handshake and no back-pressure. The clock generator, SDRAM controller, boot loader and core sit outside the block. They are seen here only as reset levels and strobes.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `ext_rst_n` is low, `pll_rst`, `core_rst`, `periph_rst` and `sdram_rst` are 1 and `rst_out` is 0. Driving the pin low asserts these resets at once, without waiting for a clock edge.
- R2: After `ext_rst_n` rises, `pll_rst` falls on the second rising clock edge (two-flop synchronizer).
- R3: After a pin reset, `core_rst`, `periph_rst` and `sdram_rst` stay 1 for exactly `LOCK_CYC` (default 4096) cycles after `pll_rst` falls, then fall together on one clock edge.
- R4: `boot_req` is a one-cycle pulse in the first cycle after a pin or software reset ends. It fires only when `boot_cfg` is 2'b00, 2'b01 or 2'b10; it stays 0 when `boot_cfg` is 2'b11.
- R5: `rst_out` is 1 exactly when the core is out of reset and `boot_cfg` is not 2'b11.
- R6: A cycle with `ctl_we`=1 and `ctl_wdata`=1 (bit 0 of the system control register) while no reset is in progress starts a software reset. `core_rst`, `periph_rst` and `sdram_rst` are then 1 for exactly `HOLD_CYC` (default 16) cycles starting the next cycle, and `pll_rst` stays 0.
- R7: `ctl_rdata` reads 1 for the whole software-reset hold and returns to 0 by itself at its end.
- R8: `run_rst_req`=1 while no reset is in progress starts a running reset. `core_rst` and `periph_rst` are 1 for exactly `HOLD_CYC` cycles, while `pll_rst` and `sdram_rst` stay 0.
- R9: At the end of a running reset, `pc_load_en` pulses for one cycle with `pc_load_val` = 20'h90005, and `boot_req` stays 0 whatever `boot_cfg` holds.
- R10: Driving the pin low during a software or running reset aborts that reset. The full pin sequence of R2 and R3 then runs.
- R11: Requests that arrive while a reset is in progress have no effect. If a software request and a running-reset request arrive in the same cycle, the software reset wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, also used as the core clock |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| ctl_we | input | 1 | Write strobe for the system control register |
| ctl_wdata | input | 1 | Write data for bit 0 (software reset) |
| ctl_rdata | output | 1 | Read-back of bit 0, 1 while a software reset is in progress |
| run_rst_req | input | 1 | Running-reset request |
| boot_cfg | input | 2 | Boot configuration pins; 2'b11 is invalid |
| pll_rst | output | 1 | Reset to the clock generator; 0 enables it |
| core_rst | output | 1 | Reset to the core, memory, program counter, stacks and counters |
| periph_rst | output | 1 | Reset to peripheral registers |
| sdram_rst | output | 1 | Reset to the SDRAM controller |
| rst_out | output | 1 | Out-of-reset indication |
| boot_req | output | 1 | One-cycle boot request |
| pc_load_en | output | 1 | One-cycle program-counter load strobe |
| pc_load_val | output | PC_W | Program-counter load value (0x90005) |

## Verification
Each request is captured on the first rising edge after it is driven, so the reset levels change in the very next cycle. The boot request or program-counter load pulse lands in the first cycle after the reset levels drop. After the pin rises, `pll_rst` stays high for two sampled cycles, and the core-side resets stay high for `LOCK_CYC` + 2 sampled cycles. The bench drives inputs just after a rising edge and samples on every falling edge. It counts how many sampled cycles each output spends high across a window that covers the whole sequence, so every due-cycle appears as an exact count.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_HW_LOCK = 2'd1,
    ST_SW_HOLD = 2'd2,
    ST_RR_HOLD = 2'd3
  } seq_state_e;

  localparam logic [1:0] BOOT_CFG_BAD = 2'b11;
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rel
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh <= '0;
    else         sh <= {sh[STAGES-2:0], 1'b1};
  end

  assign rel = sh[STAGES-1];

  // R2: release only after the first stage has already been high
  p_sync_order_r2: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rel) |-> $past(sh[0]));
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_seq_pkg::*;
#(
  parameter int LOCK_CYC = 4096,
  parameter int HOLD_CYC = 16
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       pll_ok,
  input  logic       sw_req,
  input  logic       rr_req,
  output seq_state_e state,
  output logic       boot_go,
  output logic       jump_go
);
  localparam int MAXC  = (LOCK_CYC > HOLD_CYC) ? LOCK_CYC : HOLD_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] LOCK_LAST = CNT_W'(LOCK_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state   <= ST_HW_LOCK;
      cnt     <= '0;
      boot_go <= 1'b0;
      jump_go <= 1'b0;
    end else begin
      boot_go <= 1'b0;
      jump_go <= 1'b0;
      case (state)
        ST_RUN: begin
          cnt <= '0;
          if (sw_req)      state <= ST_SW_HOLD;
          else if (rr_req) state <= ST_RR_HOLD;
        end
        ST_HW_LOCK: begin
          if (!pll_ok) cnt <= '0;
          else if (cnt == LOCK_LAST) begin
            state   <= ST_RUN;
            cnt     <= '0;
            boot_go <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        ST_SW_HOLD: begin
          if (cnt == HOLD_LAST) begin
            state   <= ST_RUN;
            cnt     <= '0;
            boot_go <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          if (cnt == HOLD_LAST) begin
            state   <= ST_RUN;
            cnt     <= '0;
            jump_go <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  // R6/R8: short holds never run past their length
  p_hold_bound_r6: assert property (@(posedge clk) disable iff (!arst_n)
    (state == ST_SW_HOLD || state == ST_RR_HOLD) |-> cnt < CNT_W'(HOLD_CYC));
  // R11: a hold is never re-entered without passing through run
  p_no_restart_r11: assert property (@(posedge clk) disable iff (!arst_n)
    (state == ST_SW_HOLD && cnt != HOLD_LAST) |=> state == ST_SW_HOLD);
  // R9: the jump strobe is a single cycle
  p_jump_pulse_r9: assert property (@(posedge clk) disable iff (!arst_n)
    jump_go |=> !jump_go);
  // R3: the lock counter stays idle until the clock generator is enabled
  p_lock_wait_r3: assert property (@(posedge clk) disable iff (!arst_n)
    (state == ST_HW_LOCK && !pll_ok) |=> cnt == '0);
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int              LOCK_CYC    = 4096,
  parameter int              HOLD_CYC    = 16,
  parameter int              SYNC_STAGES = 2,
  parameter int              PC_W        = 20,
  parameter logic [PC_W-1:0] RESET_VEC   = 20'h90005
) (
  input  logic            clk,
  input  logic            ext_rst_n,
  input  logic            ctl_we,
  input  logic            ctl_wdata,
  output logic            ctl_rdata,
  input  logic            run_rst_req,
  input  logic [1:0]      boot_cfg,
  output logic            pll_rst,
  output logic            core_rst,
  output logic            periph_rst,
  output logic            sdram_rst,
  output logic            rst_out,
  output logic            boot_req,
  output logic            pc_load_en,
  output logic [PC_W-1:0] pc_load_val
);
  seq_state_e state;
  logic       pll_ok;
  logic       boot_go;
  logic       jump_go;
  logic       cfg_ok;

  rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (ext_rst_n),
    .rel    (pll_ok)
  );

  rst_seq_fsm #(.LOCK_CYC(LOCK_CYC), .HOLD_CYC(HOLD_CYC)) u_fsm (
    .clk     (clk),
    .arst_n  (ext_rst_n),
    .pll_ok  (pll_ok),
    .sw_req  (ctl_we && ctl_wdata),
    .rr_req  (run_rst_req),
    .state   (state),
    .boot_go (boot_go),
    .jump_go (jump_go)
  );

  assign cfg_ok      = (boot_cfg != BOOT_CFG_BAD);
  assign pll_rst     = !pll_ok;
  assign core_rst    = (state != ST_RUN);
  assign periph_rst  = (state != ST_RUN);
  assign sdram_rst   = (state == ST_HW_LOCK) || (state == ST_SW_HOLD);
  assign rst_out     = (state == ST_RUN) && cfg_ok;
  assign boot_req    = boot_go && cfg_ok;
  assign pc_load_en  = jump_go;
  assign pc_load_val = RESET_VEC;
  assign ctl_rdata   = (state == ST_SW_HOLD);

  // R8: running reset spares the clock generator and SDRAM controller
  p_rr_spares_r8: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (state == ST_RR_HOLD) |-> (!pll_rst && !sdram_rst));
  // R6: software reset leaves the clock generator running
  p_sw_spares_pll_r6: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (state == ST_SW_HOLD) |-> !pll_rst);
  // R4: boot request is one cycle long
  p_boot_pulse_r4: assert property (@(posedge clk) disable iff (!ext_rst_n)
    boot_req |=> !boot_req);
  // R9: a jump never comes with a boot
  p_no_boot_on_jump_r9: assert property (@(posedge clk) disable iff (!ext_rst_n)
    pc_load_en |-> !boot_req);
  // R5: out-of-reset indication only with the core running
  p_rstout_r5: assert property (@(posedge clk) disable iff (!ext_rst_n)
    rst_out |-> !core_rst);
endmodule

// File: tb/tb_rst_seq_ctrl.sv
module tb_rst_seq_ctrl;
  localparam int LOCK = 4096;
  localparam int HOLD = 16;

  logic        clk = 1'b0;
  logic        ext_rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic        ctl_wdata = 1'b0;
  logic        run_rst_req = 1'b0;
  logic [1:0]  boot_cfg = 2'b00;
  logic        ctl_rdata, pll_rst, core_rst, periph_rst, sdram_rst;
  logic        rst_out, boot_req, pc_load_en;
  logic [19:0] pc_load_val;

  int n_chk = 0;
  int n_err = 0;
  int a_core, a_per, a_sd, a_pll, a_boot, a_pcl, a_rd, a_pcbad;

  always #10 clk = ~clk;

  rst_seq_ctrl dut (
    .clk(clk), .ext_rst_n(ext_rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .run_rst_req(run_rst_req), .boot_cfg(boot_cfg),
    .pll_rst(pll_rst), .core_rst(core_rst), .periph_rst(periph_rst),
    .sdram_rst(sdram_rst), .rst_out(rst_out), .boot_req(boot_req),
    .pc_load_en(pc_load_en), .pc_load_val(pc_load_val)
  );

  // {kind[1:0] (1 sw, 2 run, 3 both), cfg[1:0], exp_boot, exp_pcl, exp_sd_cnt[4:0]}
  localparam logic [10:0] VEC [8] = '{
    {2'd1, 2'b00, 1'b1, 1'b0, 5'd16},
    {2'd1, 2'b01, 1'b1, 1'b0, 5'd16},
    {2'd1, 2'b10, 1'b1, 1'b0, 5'd16},
    {2'd1, 2'b11, 1'b0, 1'b0, 5'd16},
    {2'd2, 2'b00, 1'b0, 1'b1, 5'd0},
    {2'd2, 2'b10, 1'b0, 1'b1, 5'd0},
    {2'd2, 2'b11, 1'b0, 1'b1, 5'd0},
    {2'd3, 2'b01, 1'b1, 1'b0, 5'd16}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr();
    a_core = 0; a_per = 0; a_sd = 0; a_pll = 0;
    a_boot = 0; a_pcl = 0; a_rd = 0; a_pcbad = 0;
  endtask

  task automatic step(input logic sw, input logic rr, input logic pin);
    @(posedge clk);
    #2;
    ctl_we = sw; ctl_wdata = sw; run_rst_req = rr; ext_rst_n = pin;
    @(negedge clk);
    a_core += int'(core_rst);  a_per += int'(periph_rst);
    a_sd   += int'(sdram_rst); a_pll += int'(pll_rst);
    a_boot += int'(boot_req);  a_pcl += int'(pc_load_en);
    a_rd   += int'(ctl_rdata);
    if (pc_load_en && pc_load_val != 20'h90005) a_pcbad++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b1);
  endtask

  task automatic check_hw(input string tag, input int eboot, input int erst);
    chk({tag, " R2 pll_rst cycles"}, a_pll, 2);
    chk({tag, " R3 core_rst cycles"}, a_core, LOCK + 2);
    chk({tag, " R3 periph_rst cycles"}, a_per, LOCK + 2);
    chk({tag, " R3 sdram_rst cycles"}, a_sd, LOCK + 2);
    chk({tag, " R4 boot pulses"}, a_boot, eboot);
    chk({tag, " R5 rst_out"}, int'(rst_out), erst);
    chk({tag, " R9 no pc load"}, a_pcl, 0);
  endtask

  initial begin
    #(20 * 100000);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    // R1: reset state with pin held low
    clr();
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0);
    chk("R1 pll_rst", a_pll, 4);
    chk("R1 core_rst", a_core, 4);
    chk("R1 sdram_rst", a_sd, 4);
    chk("R1 rst_out", int'(rst_out), 0);
    chk("R1 no boot", a_boot, 0);

    // R2 R3 R4 R5: pin release with valid boot configuration
    clr();
    step(1'b0, 1'b0, 1'b1);
    idle(LOCK + 10);
    check_hw("pin release", 1, 1);

    // Vector table: software / running resets (R6 R7 R8 R9 R4 R5 R11)
    foreach (VEC[k]) begin
      logic [1:0] kind;
      kind = VEC[k][10:9];
      boot_cfg = VEC[k][8:7];
      clr();
      step(kind[0], kind[1], 1'b1);
      idle(HOLD + 8);
      chk($sformatf("vec%0d R6 R8 core_rst cycles", k), a_core, HOLD);
      chk($sformatf("vec%0d R6 R8 periph_rst cycles", k), a_per, HOLD);
      chk($sformatf("vec%0d R6 R8 pll_rst stays low", k), a_pll, 0);
      chk($sformatf("vec%0d R8 R11 sdram_rst cycles", k), a_sd, int'(VEC[k][4:0]));
      chk($sformatf("vec%0d R4 boot pulses", k), a_boot, int'(VEC[k][6]));
      chk($sformatf("vec%0d R9 pc load pulses", k), a_pcl, int'(VEC[k][5]));
      chk($sformatf("vec%0d R9 pc load value", k), a_pcbad, 0);
      chk($sformatf("vec%0d R7 ctl_rdata cycles", k), a_rd, int'(VEC[k][4:0]));
      chk($sformatf("vec%0d R5 rst_out", k), int'(rst_out), int'(VEC[k][8:7] != 2'b11));
    end

    // R11: requests during a software reset are ignored
    boot_cfg = 2'b00;
    clr();
    step(1'b1, 1'b0, 1'b1);
    idle(5);
    step(1'b1, 1'b1, 1'b1);
    idle(HOLD + 8);
    chk("R11 core_rst single hold", a_core, HOLD);
    chk("R11 one boot", a_boot, 1);
    chk("R11 no pc load", a_pcl, 0);

    // R11: software request during a running reset is ignored
    clr();
    step(1'b0, 1'b1, 1'b1);
    idle(4);
    step(1'b1, 1'b0, 1'b1);
    idle(HOLD + 8);
    chk("R11 rr hold unchanged", a_core, HOLD);
    chk("R11 rr sdram untouched", a_sd, 0);
    chk("R11 rr no boot", a_boot, 0);
    chk("R11 rr one pc load", a_pcl, 1);

    // R10 R1: pin during software reset, then invalid boot configuration
    clr();
    step(1'b1, 1'b0, 1'b1);
    idle(5);
    clr();
    step(1'b0, 1'b0, 1'b0);
    chk("R1 async pll_rst", a_pll, 1);
    chk("R1 async sdram_rst", a_sd, 1);
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    boot_cfg = 2'b11;
    clr();
    step(1'b0, 1'b0, 1'b1);
    idle(LOCK + 10);
    check_hw("R10 sw abort", 0, 0);
    chk("R10 R7 soft bit cleared", a_rd, 0);

    // R10: pin during running reset
    boot_cfg = 2'b10;
    clr();
    step(1'b0, 1'b1, 1'b1);
    idle(3);
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    clr();
    step(1'b0, 1'b0, 1'b1);
    idle(LOCK + 10);
    check_hw("R10 rr abort", 1, 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule